// File: doc/BRIEF.md
# Outbound Link Protection Guard

This block sits between a router's crossbar and its outbound mesh links, one instance per software-visible network. Every outbound direction has its own block bit. A packet's first word is its header, and the low seven bits of that header give the number of body words that follow it. The guard checks the header against the block bits for the requested direction. An allowed packet passes through word by word, with the direction latched from the header. A packet headed for a blocked direction is stalled at the guard's input, so none of its words reach a link. The guard then records the direction and the header word in a status register and raises an interrupt.

System software reads the status to see which link was hit, and then deals with the held packet in one of two ways. It can pull the packet out one word at a time through a drain port, for example to replay it later on another link. Or it can issue a discard command, which consumes the whole packet using the header's length field. Block bits are sampled only while no packet is in flight. Protection acts only on traffic leaving the router, so one instance can close a link in one direction while the neighbour's instance keeps the reverse direction open. The status stays valid until software clears it.

Top module: `egress_link_guard`

## Requirements
- R1: After reset, out_valid, drain_valid, irq, stat_valid and in_ready are all low.
- R2: A packet whose header names an unblocked direction is forwarded in order with every word intact. All of its words leave on the direction given by the header, and in_ready follows out_ready, so out_ready low stalls the input.
- R3: A header whose direction has its block bit set is never forwarded. out_valid stays low and in_ready stays low until software acts, and irq rises one cycle after the header is first presented.
- R4: On a violation, stat_dir holds the blocked direction and stat_hdr holds the header word. Both, together with stat_valid and irq, hold steady until a stat_clear pulse.
- R5: Block bits are independent per direction. With only direction 2 blocked, a packet for direction 3 passes unchanged.
- R6: While a packet is held, each cycle with drain_req high and in_valid high consumes one word. That word is presented on drain_data with drain_valid high and out_valid low. After the header and all of its body words have been drained, the next packet is handled normally.
- R7: A discard pulse on a held packet consumes exactly one header plus the number of body words given by its length field, at one word per cycle. None of these words reaches the link, and the packet after them is handled normally.
- R8: A change on block_mask while a packet is in flight does not affect that packet. The new mask applies to headers presented at least one idle cycle after the packet ends.
- R9: If a second blocked header arrives while stat_valid is still set, the status is not overwritten and the header stays stalled. After stat_clear, it is recorded one cycle later.
- R10: The header's bits [6:0] give the body length, so a header with length 0 is a one-word packet and the very next word is treated as a new header.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| block_mask | input | 4 | Per-direction block bits from software, bit i closes direction i |
| in_valid | input | 1 | Word offered by the crossbar |
| in_dir | input | 2 | Requested outbound direction, read on header words |
| in_data | input | 32 | Packet word; the header carries the length in bits [6:0] |
| in_ready | output | 1 | Word accepted this cycle |
| out_valid | output | 1 | Word presented to the outbound link |
| out_dir | output | 2 | Direction of the presented word |
| out_data | output | 32 | Word presented to the link |
| out_ready | input | 1 | Link can accept a word |
| drain_req | input | 1 | Software pops one held word |
| drain_valid | output | 1 | A held word is consumed this cycle |
| drain_data | output | 32 | The held word being consumed |
| discard | input | 1 | Pulse: throw away the held packet |
| stat_clear | input | 1 | Pulse: clear the violation status |
| stat_valid | output | 1 | Violation status is valid |
| stat_dir | output | 2 | Direction that was blocked |
| stat_hdr | output | 32 | Header word of the blocked packet |
| irq | output | 1 | Interrupt to system software |

## Verification
Directed packets are sent both to open and to closed directions. The forwarding path is tested with a stalled link and with a one-word packet. The one-word packet shows whether the length field ends a packet at the right word. Blocked packets are then cleared by draining and by discarding. In both cases a follow-up packet is sent to check that exactly header plus length words were consumed. A mask flip in the middle of a packet separates boundary-aligned mask updates from immediate ones. A second violation raised while the status is still pending shows whether the status is overwritten or deferred.

// File: rtl/egress_guard_pkg.sv
package egress_guard_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_PASS  = 2'd1,
        ST_HOLD  = 2'd2,
        ST_PURGE = 2'd3
    } guard_state_e;
endpackage

// File: rtl/olg_mask_stage.sv
module olg_mask_stage #(
    parameter int NUM_DIR = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_DIR-1:0] mask_in,
    input  logic               boundary,
    output logic [NUM_DIR-1:0] mask_act
);
    typedef struct packed {
        logic [NUM_DIR-1:0] mask;
    } regs_t;

    regs_t r_d, r_q;

    // New block bits are taken only while no packet is in flight.
    always_comb begin
        r_d = r_q;
        if (boundary) r_d.mask = mask_in;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign mask_act = r_q.mask;
endmodule

// File: rtl/olg_status.sv
module olg_status #(
    parameter int DATA_W = 32,
    parameter int DIR_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rec,
    input  logic [DIR_W-1:0]  rec_dir,
    input  logic [DATA_W-1:0] rec_hdr,
    input  logic              clr,
    output logic              valid,
    output logic [DIR_W-1:0]  dir,
    output logic [DATA_W-1:0] hdr
);
    typedef struct packed {
        logic              valid;
        logic [DIR_W-1:0]  dir;
        logic [DATA_W-1:0] hdr;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (rec) begin
            r_d.valid = 1'b1;
            r_d.dir   = rec_dir;
            r_d.hdr   = rec_hdr;
        end else if (clr) begin
            r_d.valid = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign valid = r_q.valid;
    assign dir   = r_q.dir;
    assign hdr   = r_q.hdr;
endmodule

// File: rtl/olg_seq.sv
module olg_seq
    import egress_guard_pkg::*;
#(
    parameter int NUM_DIR = 4,
    parameter int DATA_W  = 32,
    parameter int LEN_W   = 7,
    localparam int DIR_W  = $clog2(NUM_DIR),
    localparam int REM_W  = LEN_W + 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_DIR-1:0] mask,
    input  logic               stat_busy,
    input  logic               in_valid,
    input  logic [DIR_W-1:0]   in_dir,
    input  logic [DATA_W-1:0]  in_data,
    output logic               in_ready,
    output logic               out_valid,
    output logic [DIR_W-1:0]   out_dir,
    output logic [DATA_W-1:0]  out_data,
    input  logic               out_ready,
    input  logic               drain_req,
    output logic               drain_valid,
    output logic [DATA_W-1:0]  drain_data,
    input  logic               discard,
    output logic               rec,
    output logic               at_boundary
);
    typedef struct packed {
        guard_state_e     st;
        logic [REM_W-1:0] rem;
        logic [DIR_W-1:0] dir;
    } regs_t;

    regs_t r_d, r_q;

    logic             blocked;
    logic [LEN_W-1:0] hdr_len;

    assign hdr_len = in_data[LEN_W-1:0];

    always_comb begin
        blocked = 1'b0;
        for (int i = 0; i < NUM_DIR; i++) begin
            if (in_dir == i[DIR_W-1:0]) blocked = mask[i];
        end
    end

    always_comb begin
        r_d         = r_q;
        in_ready    = 1'b0;
        out_valid   = 1'b0;
        out_dir     = r_q.dir;
        out_data    = in_data;
        drain_valid = 1'b0;
        drain_data  = in_data;
        rec         = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (in_valid && !blocked) begin
                    out_valid = 1'b1;
                    out_dir   = in_dir;
                    in_ready  = out_ready;
                    if (out_ready && hdr_len != '0) begin
                        r_d.st  = ST_PASS;
                        r_d.rem = {1'b0, hdr_len};
                        r_d.dir = in_dir;
                    end
                end else if (in_valid && !stat_busy) begin
                    // Violation: hold the header at the input, record it once.
                    rec     = 1'b1;
                    r_d.st  = ST_HOLD;
                    r_d.rem = {1'b0, hdr_len} + REM_W'(1);
                    r_d.dir = in_dir;
                end
            end
            ST_PASS: begin
                out_valid = in_valid;
                in_ready  = out_ready;
                if (in_valid && out_ready) begin
                    r_d.rem = r_q.rem - REM_W'(1);
                    if (r_q.rem == REM_W'(1)) r_d.st = ST_IDLE;
                end
            end
            ST_HOLD: begin
                if (discard) begin
                    r_d.st = ST_PURGE;
                end else if (drain_req && in_valid) begin
                    in_ready    = 1'b1;
                    drain_valid = 1'b1;
                    r_d.rem     = r_q.rem - REM_W'(1);
                    if (r_q.rem == REM_W'(1)) r_d.st = ST_IDLE;
                end
            end
            ST_PURGE: begin
                in_ready = 1'b1;
                if (in_valid) begin
                    r_d.rem = r_q.rem - REM_W'(1);
                    if (r_q.rem == REM_W'(1)) r_d.st = ST_IDLE;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '{st: ST_IDLE, rem: '0, dir: '0};
        else        r_q <= r_d;
    end

    assign at_boundary = (r_q.st == ST_IDLE);
endmodule

// File: rtl/egress_link_guard.sv
module egress_link_guard #(
    parameter int NUM_DIR = 4,
    parameter int DATA_W  = 32,
    parameter int LEN_W   = 7,
    localparam int DIR_W  = $clog2(NUM_DIR)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_DIR-1:0] block_mask,
    input  logic               in_valid,
    input  logic [DIR_W-1:0]   in_dir,
    input  logic [DATA_W-1:0]  in_data,
    output logic               in_ready,
    output logic               out_valid,
    output logic [DIR_W-1:0]   out_dir,
    output logic [DATA_W-1:0]  out_data,
    input  logic               out_ready,
    input  logic               drain_req,
    output logic               drain_valid,
    output logic [DATA_W-1:0]  drain_data,
    input  logic               discard,
    input  logic               stat_clear,
    output logic               stat_valid,
    output logic [DIR_W-1:0]   stat_dir,
    output logic [DATA_W-1:0]  stat_hdr,
    output logic               irq
);
    logic [NUM_DIR-1:0] mask_act;
    logic               at_boundary;
    logic               rec;

    olg_mask_stage #(.NUM_DIR(NUM_DIR)) u_mask (
        .clk      (clk),
        .rst_n    (rst_n),
        .mask_in  (block_mask),
        .boundary (at_boundary),
        .mask_act (mask_act)
    );

    olg_seq #(.NUM_DIR(NUM_DIR), .DATA_W(DATA_W), .LEN_W(LEN_W)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .mask        (mask_act),
        .stat_busy   (stat_valid),
        .in_valid    (in_valid),
        .in_dir      (in_dir),
        .in_data     (in_data),
        .in_ready    (in_ready),
        .out_valid   (out_valid),
        .out_dir     (out_dir),
        .out_data    (out_data),
        .out_ready   (out_ready),
        .drain_req   (drain_req),
        .drain_valid (drain_valid),
        .drain_data  (drain_data),
        .discard     (discard),
        .rec         (rec),
        .at_boundary (at_boundary)
    );

    olg_status #(.DATA_W(DATA_W), .DIR_W(DIR_W)) u_stat (
        .clk     (clk),
        .rst_n   (rst_n),
        .rec     (rec),
        .rec_dir (in_dir),
        .rec_hdr (in_data),
        .clr     (stat_clear),
        .valid   (stat_valid),
        .dir     (stat_dir),
        .hdr     (stat_hdr)
    );

    assign irq = stat_valid;
endmodule

// File: rtl/egress_link_guard_chk.sv
module egress_link_guard_chk #(
    parameter int NUM_DIR = 4,
    parameter int DATA_W  = 32,
    localparam int DIR_W  = $clog2(NUM_DIR)
) (
    input logic               clk,
    input logic               rst_n,
    input logic               in_valid,
    input logic               in_ready,
    input logic               out_valid,
    input logic               out_ready,
    input logic [DIR_W-1:0]   out_dir,
    input logic               drain_valid,
    input logic               stat_valid,
    input logic               stat_clear,
    input logic [DIR_W-1:0]   stat_dir,
    input logic [DATA_W-1:0]  stat_hdr,
    input logic [NUM_DIR-1:0] mask_act,
    input logic               at_boundary
);
    // R2: a stalled link must stall the input
    p_stall_r2: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |-> !in_ready);

    // R3: a header leaving at a boundary never targets a closed direction
    p_no_blocked_hdr_r3: assert property (@(posedge clk) disable iff (!rst_n)
        at_boundary && out_valid |-> !mask_act[out_dir]);

    // R4 and R9: the status holds until cleared
    p_status_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        stat_valid && !stat_clear |=> stat_valid && $stable(stat_dir) && $stable(stat_hdr));

    // R6: a drained word is consumed and never reaches the link
    p_drain_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
        drain_valid |-> in_valid && in_ready && !out_valid);

    // R8: block bits do not move while a packet is in flight
    p_mask_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !at_boundary |=> $stable(mask_act));
endmodule

bind egress_link_guard egress_link_guard_chk #(.NUM_DIR(NUM_DIR), .DATA_W(DATA_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .in_ready    (in_ready),
    .out_valid   (out_valid),
    .out_ready   (out_ready),
    .out_dir     (out_dir),
    .drain_valid (drain_valid),
    .stat_valid  (stat_valid),
    .stat_clear  (stat_clear),
    .stat_dir    (stat_dir),
    .stat_hdr    (stat_hdr),
    .mask_act    (mask_act),
    .at_boundary (at_boundary)
);

// File: tb/tb_egress_link_guard.sv
module tb_egress_link_guard;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [3:0]  block_mask;
    logic        in_valid;
    logic [1:0]  in_dir;
    logic [31:0] in_data;
    logic        in_ready;
    logic        out_valid;
    logic [1:0]  out_dir;
    logic [31:0] out_data;
    logic        out_ready;
    logic        drain_req;
    logic        drain_valid;
    logic [31:0] drain_data;
    logic        discard;
    logic        stat_clear;
    logic        stat_valid;
    logic [1:0]  stat_dir;
    logic [31:0] stat_hdr;
    logic        irq;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    egress_link_guard dut (
        .clk(clk), .rst_n(rst_n), .block_mask(block_mask),
        .in_valid(in_valid), .in_dir(in_dir), .in_data(in_data), .in_ready(in_ready),
        .out_valid(out_valid), .out_dir(out_dir), .out_data(out_data), .out_ready(out_ready),
        .drain_req(drain_req), .drain_valid(drain_valid), .drain_data(drain_data),
        .discard(discard), .stat_clear(stat_clear), .stat_valid(stat_valid),
        .stat_dir(stat_dir), .stat_hdr(stat_hdr), .irq(irq)
    );

    function automatic logic [31:0] mk_hdr(input int len, input int tag);
        return {tag[24:0], len[6:0]};
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Apply inputs after a falling edge and let combinational outputs settle.
    task automatic step(input logic v, input logic [1:0] d, input logic [31:0] w,
                        input logic ordy, input logic dreq, input logic disc, input logic clr);
        @(negedge clk);
        in_valid = v; in_dir = d; in_data = w; out_ready = ordy;
        drain_req = dreq; discard = disc; stat_clear = clr;
        #1;
    endtask

    task automatic idle();
        step(1'b0, 2'd0, 32'h0, 1'b1, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic t_reset();
        idle();
        chk(out_valid == 1'b0, "R1 out_valid", {31'b0, out_valid}, 0);
        chk(irq == 1'b0 && stat_valid == 1'b0, "R1 irq", {31'b0, irq}, 0);
        chk(in_ready == 1'b0 && drain_valid == 1'b0, "R1 in_ready", {31'b0, in_ready}, 0);
    endtask

    task automatic t_forward();
        logic [31:0] h  = mk_hdr(2, 'h11);
        logic [31:0] z  = mk_hdr(0, 'h22);
        logic [31:0] h3 = mk_hdr(1, 'h33);
        step(1'b1, 2'd1, h, 1'b1, 1'b0, 1'b0, 1'b0);
        chk(out_valid && out_dir == 2'd1 && out_data == h && in_ready, "R2 header", out_data, h);
        step(1'b1, 2'd0, 32'hB1, 1'b0, 1'b0, 1'b0, 1'b0);
        chk(out_valid && !in_ready, "R2 stall", {31'b0, in_ready}, 0);
        step(1'b1, 2'd0, 32'hB1, 1'b1, 1'b0, 1'b0, 1'b0);
        chk(out_valid && out_dir == 2'd1 && out_data == 32'hB1 && in_ready, "R2 body1 dir", {30'b0, out_dir}, 1);
        step(1'b1, 2'd0, 32'hB2, 1'b1, 1'b0, 1'b0, 1'b0);
        chk(out_valid && out_dir == 2'd1 && out_data == 32'hB2, "R2 body2", out_data, 32'hB2);
        idle();
        chk(!out_valid, "R2 end", {31'b0, out_valid}, 0);
        // R10: zero-length packet, next word must be a fresh header
        step(1'b1, 2'd0, z, 1'b1, 1'b0, 1'b0, 1'b0);
        chk(out_valid && out_dir == 2'd0, "R10 single", {30'b0, out_dir}, 0);
        step(1'b1, 2'd3, h3, 1'b1, 1'b0, 1'b0, 1'b0);
        chk(out_valid && out_dir == 2'd3, "R10 next header", {30'b0, out_dir}, 3);
        step(1'b1, 2'd0, 32'hC1, 1'b1, 1'b0, 1'b0, 1'b0);
        chk(out_valid && out_dir == 2'd3, "R10 body", {30'b0, out_dir}, 3);
        idle();
    endtask

    task automatic t_block_drain();
        logic [31:0] h  = mk_hdr(2, 'h44);
        logic [31:0] p3 = mk_hdr(0, 'h55);
        block_mask = 4'b0100;
        idle();
        // R5: direction 3 unaffected
        step(1'b1, 2'd3, p3, 1'b1, 1'b0, 1'b0, 1'b0);
        chk(out_valid && out_dir == 2'd3 && in_ready, "R5 open dir", {31'b0, out_valid}, 1);
        step(1'b1, 2'd2, h, 1'b1, 1'b0, 1'b0, 1'b0);
        chk(!out_valid && !in_ready, "R3 held", {31'b0, out_valid}, 0);
        chk(!irq, "R3 irq latency", {31'b0, irq}, 0);
        step(1'b1, 2'd2, h, 1'b1, 1'b0, 1'b0, 1'b0);
        chk(irq && !out_valid, "R3 irq", {31'b0, irq}, 1);
        chk(stat_valid && stat_dir == 2'd2 && stat_hdr == h, "R4 status", stat_hdr, h);
        step(1'b1, 2'd2, h, 1'b1, 1'b1, 1'b0, 1'b0);
        chk(drain_valid && drain_data == h && !out_valid && in_ready, "R6 drain hdr", drain_data, h);
        step(1'b1, 2'd0, 32'hD1, 1'b1, 1'b1, 1'b0, 1'b0);
        chk(drain_valid && drain_data == 32'hD1, "R6 drain b1", drain_data, 32'hD1);
        step(1'b1, 2'd0, 32'hD2, 1'b1, 1'b1, 1'b0, 1'b0);
        chk(drain_valid && drain_data == 32'hD2 && !out_valid, "R6 drain b2", drain_data, 32'hD2);
        step(1'b1, 2'd3, p3, 1'b1, 1'b0, 1'b0, 1'b0);
        chk(out_valid && out_dir == 2'd3 && !drain_valid, "R6 resume", {31'b0, out_valid}, 1);
        chk(irq && stat_hdr == h, "R4 held status", stat_hdr, h);
        step(1'b0, 2'd0, 32'h0, 1'b1, 1'b0, 1'b0, 1'b1);
        idle();
        chk(!irq && !stat_valid, "R4 clear", {31'b0, irq}, 0);
    endtask

    task automatic t_discard();
        logic [31:0] h = mk_hdr(1, 'h66);
        logic [31:0] n = mk_hdr(0, 'h77);
        step(1'b1, 2'd2, h, 1'b1, 1'b0, 1'b0, 1'b0);
        step(1'b1, 2'd2, h, 1'b1, 1'b0, 1'b1, 1'b0);
        chk(!in_ready && irq, "R7 discard cmd", {31'b0, in_ready}, 0);
        step(1'b1, 2'd2, h, 1'b1, 1'b0, 1'b0, 1'b0);
        chk(in_ready && !out_valid && !drain_valid, "R7 drop hdr", {31'b0, in_ready}, 1);
        step(1'b1, 2'd0, 32'hE1, 1'b1, 1'b0, 1'b0, 1'b0);
        chk(in_ready && !out_valid, "R7 drop body", {31'b0, in_ready}, 1);
        step(1'b1, 2'd1, n, 1'b1, 1'b0, 1'b0, 1'b0);
        chk(out_valid && out_dir == 2'd1 && out_data == n, "R7 next pkt", out_data, n);
        step(1'b0, 2'd0, 32'h0, 1'b1, 1'b0, 1'b0, 1'b1);
        idle();
    endtask

    task automatic t_second_violation();
        logic [31:0] a = mk_hdr(0, 'hA0);
        logic [31:0] b = mk_hdr(0, 'hB0);
        step(1'b1, 2'd2, a, 1'b1, 1'b0, 1'b0, 1'b0);
        step(1'b1, 2'd2, a, 1'b1, 1'b1, 1'b0, 1'b0);
        chk(drain_valid && drain_data == a, "R6 drain one", drain_data, a);
        step(1'b1, 2'd2, b, 1'b1, 1'b0, 1'b0, 1'b0);
        step(1'b1, 2'd2, b, 1'b1, 1'b0, 1'b0, 1'b0);
        chk(stat_hdr == a && !in_ready && !out_valid, "R9 no overwrite", stat_hdr, a);
        step(1'b1, 2'd2, b, 1'b1, 1'b0, 1'b0, 1'b1);
        step(1'b1, 2'd2, b, 1'b1, 1'b0, 1'b0, 1'b0);
        chk(!irq, "R9 cleared", {31'b0, irq}, 0);
        step(1'b1, 2'd2, b, 1'b1, 1'b0, 1'b0, 1'b0);
        chk(irq && stat_hdr == b, "R9 recorded", stat_hdr, b);
        step(1'b1, 2'd2, b, 1'b1, 1'b0, 1'b1, 1'b0);
        step(1'b1, 2'd2, b, 1'b1, 1'b0, 1'b0, 1'b0);
        step(1'b0, 2'd0, 32'h0, 1'b1, 1'b0, 1'b0, 1'b1);
        idle();
    endtask

    task automatic t_mask_boundary();
        logic [31:0] h = mk_hdr(2, 'hC0);
        block_mask = 4'b0000;
        idle();
        step(1'b1, 2'd2, h, 1'b1, 1'b0, 1'b0, 1'b0);
        chk(out_valid && out_dir == 2'd2, "R8 open hdr", {31'b0, out_valid}, 1);
        block_mask = 4'b0100;
        step(1'b1, 2'd0, 32'hF1, 1'b1, 1'b0, 1'b0, 1'b0);
        chk(out_valid && out_dir == 2'd2 && out_data == 32'hF1, "R8 in flight", {31'b0, out_valid}, 1);
        step(1'b1, 2'd0, 32'hF2, 1'b1, 1'b0, 1'b0, 1'b0);
        chk(out_valid && out_data == 32'hF2, "R8 tail", out_data, 32'hF2);
        idle();
        step(1'b1, 2'd2, h, 1'b1, 1'b0, 1'b0, 1'b0);
        chk(!out_valid && !in_ready, "R8 applied", {31'b0, out_valid}, 0);
        step(1'b1, 2'd2, h, 1'b1, 1'b0, 1'b1, 1'b0);
        for (int i = 0; i < 3; i++) step(1'b1, 2'd2, h, 1'b1, 1'b0, 1'b0, 1'b0);
        step(1'b0, 2'd0, 32'h0, 1'b1, 1'b0, 1'b0, 1'b1);
        idle();
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        total++;
        bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        finish_run();
    end

    initial begin
        rst_n = 1'b0; block_mask = '0; in_valid = 1'b0; in_dir = '0; in_data = '0;
        out_ready = 1'b1; drain_req = 1'b0; discard = 1'b0; stat_clear = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_forward();
        t_block_drain();
        t_discard();
        t_second_violation();
        t_mask_boundary();
        finish_run();
    end
endmodule